// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block is the power-state controller on the device side of a small serial sampling converter. It samples two asynchronous pins, the convert-start strobe and the serial clock, into a fast system clock. From their activity it picks one of four states: active, automatic nap after a finished conversion, commanded nap, and commanded sleep. It drives four flags: a bias enable, a reference enable, a conversion-allowed flag and a reference-ready flag.

A host puts the converter into a power-down mode by pulsing the convert strobe while the serial clock stays still. Two pulses select nap and four select sleep. A single serial-clock movement wakes the device from either mode. The reference needs time to recover after a wake, and this recovery is modelled by a counter. The wait is short after nap and long after sleep, and each length is set by its own parameter. Conversion length is also set by a parameter, and the end of a conversion drops the block into automatic nap by itself.

Top module: `psq_top`

## Requirements
- R1: With no serial-clock transition between them, two convert-strobe rising edges put the block into commanded nap. The flags {biasEn, refEn, convAllowed, refReady} then read 0,1,0,1.
- R2: Four such rising edges with the serial clock still put the block into sleep, where all four flags read 0.
- R3: A rising convert edge in active state with conversion allowed starts a conversion of CONV_CYCLES cycles. At its end the block enters automatic nap (flags 0,1,1,1) with no command. A falling convert edge then returns it to active (flags 1,1,1,1).
- R4: In commanded nap the reference stays enabled. After a wake from nap, conversion is blocked only for NAP_WAKE_CYCLES cycles, during which the flags read 1,1,0,0.
- R5: In sleep, both bias and reference are disabled.
- R6: Any serial-clock transition, rising or falling, returns the block from nap or sleep to active.
- R7: After a wake from sleep, refReady and convAllowed stay low for SLEEP_WAKE_CYCLES cycles while bias and reference are enabled. Only then do they rise.
- R8: Any serial-clock transition clears the convert-pulse count. If a convert rising edge arrives in the same cycle as a serial-clock transition, the count becomes 1.
- R9: A synchronous reset puts the block into active with all four flags high, and no recovery wait is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| convPin | input | 1 | Asynchronous convert-start strobe |
| sckPin | input | 1 | Asynchronous serial clock |
| biasEn | output | 1 | Full bias enable |
| refEn | output | 1 | Bandgap and reference buffer enable |
| convAllowed | output | 1 | A new conversion may start |
| refReady | output | 1 | Reference recovery has finished |

## Verification
Two events can land in the same cycle: a serial-clock transition, which clears the pulse count, and a convert rising edge, which advances it. The bench drives both pins in the same half-cycle, so they reach the edge detector together. It then applies exactly one further convert pulse. The result is accepted only if that single pulse produces commanded nap. That proves the colliding edge was counted as 1: a count of 0 would leave the block active, and a count of 2 would have produced nap one pulse earlier.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_AUTONAP = 2'd1,
    PS_NAP     = 2'd2,
    PS_SLEEP   = 2'd3
  } pwrState_t;

  localparam int PULSE_W      = 3;
  localparam int NAP_PULSES   = 2;
  localparam int SLEEP_PULSES = 4;

  // control -> datapath
  typedef struct packed {
    logic startConv;
    logic loadNapWake;
    logic loadSleepWake;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic               convRise;
    logic               convFall;
    logic               sckEdge;
    logic               convDone;
    logic               recoveryIdle;
    logic [PULSE_W-1:0] pulseCount;
  } dpStatus_t;

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/psq_datapath.sv
module psq_datapath
  import psq_pkg::*;
#(
  parameter int SYNC_STAGES       = 2,
  parameter int CONV_CYCLES       = 8,
  parameter int NAP_WAKE_CYCLES   = 13,
  parameter int SLEEP_WAKE_CYCLES = 275000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        convPin,
  input  logic        sckPin,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int CONV_W  = $clog2(CONV_CYCLES + 1);
  localparam int REC_MAX = (SLEEP_WAKE_CYCLES > NAP_WAKE_CYCLES) ? SLEEP_WAKE_CYCLES : NAP_WAKE_CYCLES;
  localparam int REC_W   = $clog2(REC_MAX + 1);
  localparam logic [PULSE_W-1:0] PULSE_SAT = PULSE_W'(SLEEP_PULSES);

  logic [1:0] pinSync;
  logic [1:0] pinPrev;
  logic convRise, convFall, sckEdge;
  logic [PULSE_W-1:0] pulseCount;
  logic [CONV_W-1:0]  convTimer;
  logic [REC_W-1:0]   recoveryCnt;

  psq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({sckPin, convPin}),
    .syncOut (pinSync)
  );

  always_ff @(posedge clk) begin
    if (rst) pinPrev <= '0;
    else     pinPrev <= pinSync;
  end

  assign convRise = pinSync[0] & ~pinPrev[0];
  assign convFall = ~pinSync[0] & pinPrev[0];
  assign sckEdge  = pinSync[1] ^ pinPrev[1];

  // convert-pulse counter: cleared by serial-clock activity, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      pulseCount <= '0;
    end else if (sckEdge) begin
      pulseCount <= convRise ? PULSE_W'(1) : '0;
    end else if (convRise && pulseCount < PULSE_SAT) begin
      pulseCount <= pulseCount + 1'b1;
    end
  end

  // conversion timer standing in for the internal oscillator
  always_ff @(posedge clk) begin
    if (rst)                   convTimer <= '0;
    else if (strobe.startConv) convTimer <= CONV_W'(CONV_CYCLES);
    else if (convTimer != '0)  convTimer <= convTimer - 1'b1;
  end

  // reference recovery counter
  always_ff @(posedge clk) begin
    if (rst)                          recoveryCnt <= '0;
    else if (strobe.loadSleepWake)    recoveryCnt <= REC_W'(SLEEP_WAKE_CYCLES);
    else if (strobe.loadNapWake)      recoveryCnt <= REC_W'(NAP_WAKE_CYCLES);
    else if (recoveryCnt != '0)       recoveryCnt <= recoveryCnt - 1'b1;
  end

  assign status.convRise     = convRise;
  assign status.convFall     = convFall;
  assign status.sckEdge      = sckEdge;
  assign status.convDone     = (convTimer == CONV_W'(1));
  assign status.recoveryIdle = (recoveryCnt == '0);
  assign status.pulseCount   = pulseCount;

  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sckEdge && !convRise) |=> (pulseCount == '0)) else $error("count not cleared"); // R8

  AST_COUNT_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (sckEdge && convRise) |=> (pulseCount == PULSE_W'(1))) else $error("collision count"); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!sckEdge && convRise && pulseCount < PULSE_SAT) |=> (pulseCount == $past(pulseCount) + 1'b1))
    else $error("count step"); // R1

  AST_SLEEP_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobe.loadSleepWake |=> !status.recoveryIdle) else $error("sleep wait missing"); // R7

endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        biasEn,
  output logic        refEn,
  output logic        convAllowed,
  output logic        refReady
);

  localparam logic [PULSE_W-1:0] NAP_CNT   = PULSE_W'(NAP_PULSES);
  localparam logic [PULSE_W-1:0] SLEEP_CNT = PULSE_W'(SLEEP_PULSES);

  pwrState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      PS_ACTIVE: begin
        if (!status.sckEdge) begin
          if (status.pulseCount >= SLEEP_CNT)    stateNext = PS_SLEEP;
          else if (status.pulseCount >= NAP_CNT) stateNext = PS_NAP;
          else if (status.convDone)              stateNext = PS_AUTONAP;
        end
      end
      PS_AUTONAP: begin
        if (!status.sckEdge) begin
          if (status.pulseCount >= SLEEP_CNT)    stateNext = PS_SLEEP;
          else if (status.pulseCount >= NAP_CNT) stateNext = PS_NAP;
          else if (status.convFall)              stateNext = PS_ACTIVE;
        end
      end
      PS_NAP: begin
        if (status.sckEdge)                      stateNext = PS_ACTIVE;
        else if (status.pulseCount >= SLEEP_CNT) stateNext = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (status.sckEdge) stateNext = PS_ACTIVE;
      end
      default: stateNext = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PS_ACTIVE;
    else     state <= stateNext;
  end

  assign biasEn      = (state == PS_ACTIVE);
  assign refEn       = (state != PS_SLEEP);
  assign refReady    = refEn && status.recoveryIdle;
  assign convAllowed = refReady && (state == PS_ACTIVE || state == PS_AUTONAP);

  assign strobe.startConv     = (state == PS_ACTIVE) && status.convRise && convAllowed;
  assign strobe.loadNapWake   = (state == PS_NAP)    && status.sckEdge;
  assign strobe.loadSleepWake = (state == PS_SLEEP)  && status.sckEdge;

  AST_WAKE_ON_SCK: assert property (@(posedge clk) disable iff (rst)
    ((state == PS_NAP || state == PS_SLEEP) && status.sckEdge) |=> (state == PS_ACTIVE))
    else $error("no wake"); // R6

  AST_AUTO_NAP: assert property (@(posedge clk) disable iff (rst)
    (state == PS_ACTIVE && status.convDone && !status.sckEdge && status.pulseCount < NAP_CNT)
    |=> (state == PS_AUTONAP)) else $error("no auto nap"); // R3

  AST_NAP_KEEPS_REF: assert property (@(posedge clk) disable iff (rst)
    (state == PS_NAP && !status.sckEdge && status.pulseCount < SLEEP_CNT) |=> refEn)
    else $error("nap dropped reference"); // R4

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == PS_NAP && !status.sckEdge && status.pulseCount >= SLEEP_CNT) |=> (!biasEn && !refEn))
    else $error("sleep kept power"); // R5

  AST_SLEEP_WAKE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SLEEP && status.sckEdge) |=> (!refReady && !convAllowed))
    else $error("sleep wake not blocked"); // R7

endmodule

// File: rtl/psq_top.sv
module psq_top
  import psq_pkg::*;
#(
  parameter int SYNC_STAGES       = 2,
  parameter int CONV_CYCLES       = 8,
  parameter int NAP_WAKE_CYCLES   = 13,
  parameter int SLEEP_WAKE_CYCLES = 275000
) (
  input  logic clk,
  input  logic rst,
  input  logic convPin,
  input  logic sckPin,
  output logic biasEn,
  output logic refEn,
  output logic convAllowed,
  output logic refReady
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  psq_datapath #(
    .SYNC_STAGES       (SYNC_STAGES),
    .CONV_CYCLES       (CONV_CYCLES),
    .NAP_WAKE_CYCLES   (NAP_WAKE_CYCLES),
    .SLEEP_WAKE_CYCLES (SLEEP_WAKE_CYCLES)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .convPin (convPin),
    .sckPin  (sckPin),
    .strobe  (strobe),
    .status  (status)
  );

  psq_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .status      (status),
    .strobe      (strobe),
    .biasEn      (biasEn),
    .refEn       (refEn),
    .convAllowed (convAllowed),
    .refReady    (refReady)
  );

endmodule

// File: tb/psq_top_tb_top.sv
module psq_top_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic convPin = 1'b0;
  logic sckPin  = 1'b0;
  logic biasEn, refEn, convAllowed, refReady;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  psq_top #(
    .SYNC_STAGES       (2),
    .CONV_CYCLES       (8),
    .NAP_WAKE_CYCLES   (3),
    .SLEEP_WAKE_CYCLES (40)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .convPin     (convPin),
    .sckPin      (sckPin),
    .biasEn      (biasEn),
    .refEn       (refEn),
    .convAllowed (convAllowed),
    .refReady    (refReady)
  );

  // {conv, sck, waitCycles[7:0], expected {biasEn, refEn, convAllowed, refReady}}
  localparam int NVEC = 15;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd10, 4'b1111},  // R9 idle active
    {1'b1, 1'b0, 8'd20, 4'b0111},  // R3 conversion -> auto nap
    {1'b0, 1'b0, 8'd10, 4'b1111},  // R3 fall -> active
    {1'b0, 1'b1, 8'd10, 4'b1111},  // R8 sck clears count
    {1'b0, 1'b0, 8'd10, 4'b1111},  // R8
    {1'b1, 1'b0, 8'd20, 4'b0111},  // R8 first pulse again, auto nap
    {1'b0, 1'b0, 8'd10, 4'b1111},  // R3
    {1'b1, 1'b0, 8'd10, 4'b0101},  // R1 second pulse -> nap
    {1'b0, 1'b0, 8'd10, 4'b0101},  // R1
    {1'b1, 1'b0, 8'd10, 4'b0101},  // R4 third pulse, still nap
    {1'b0, 1'b0, 8'd10, 4'b0101},  // R4
    {1'b1, 1'b0, 8'd10, 4'b0000},  // R2 fourth pulse -> sleep
    {1'b0, 1'b0, 8'd10, 4'b0000},  // R5 sleep holds
    {1'b0, 1'b1, 8'd60, 4'b1111},  // R6 sck wakes, R7 recovered
    {1'b0, 1'b0, 8'd10, 4'b1111}   // R6
  };

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkFlags(string req, logic [3:0] expFlags);
    logic [3:0] got;
    got = {biasEn, refEn, convAllowed, refReady};
    checks++;
    if (got !== expFlags) begin
      fails++;
      $display("FAIL %s flags got=%b expected=%b at %0t", req, got, expFlags, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired got=running expected=finished");
    finishRun();
  end

  initial begin
    waitCycles(4);
    rst = 1'b0;
    waitCycles(2);
    checkFlags("R9 reset state", 4'b1111);

    for (int v = 0; v < NVEC; v++) begin
      convPin = VEC[v][13];
      sckPin  = VEC[v][12];
      waitCycles(int'(VEC[v][11:4]));
      checkFlags($sformatf("R1-table row %0d", v), VEC[v][3:0]);
    end

    // R4: commanded nap then wake, short recovery window
    convPin = 1'b1; waitCycles(20);
    convPin = 1'b0; waitCycles(10);
    convPin = 1'b1; waitCycles(10);
    checkFlags("R1 nap entered", 4'b0101);
    convPin = 1'b0; waitCycles(10);
    sckPin = 1'b1;
    waitCycles(3);
    checkFlags("R4 nap wake window", 4'b1100);
    waitCycles(10);
    checkFlags("R4 nap wake done", 4'b1111);

    // R7: sleep then wake, long recovery window
    for (int p = 0; p < 4; p++) begin
      convPin = 1'b1; waitCycles(12);
      convPin = 1'b0; waitCycles(12);
    end
    checkFlags("R2 R5 sleep entered", 4'b0000);
    sckPin = 1'b0;
    waitCycles(20);
    checkFlags("R7 sleep wake window", 4'b1100);
    waitCycles(30);
    checkFlags("R7 sleep wake done", 4'b1111);

    // R8: convert rise and serial-clock transition collide
    convPin = 1'b1;
    sckPin  = 1'b1;
    waitCycles(20);
    checkFlags("R8 collide auto nap", 4'b0111);
    convPin = 1'b0; waitCycles(10);
    checkFlags("R8 collide back active", 4'b1111);
    convPin = 1'b1; waitCycles(10);
    checkFlags("R8 collide counted as one", 4'b0101);

    // R9: reset from commanded nap
    convPin = 1'b0;
    waitCycles(5);
    rst = 1'b1;
    waitCycles(3);
    rst = 1'b0;
    waitCycles(2);
    checkFlags("R9 reset from nap", 4'b1111);

    finishRun();
  end

endmodule